// File: doc/BRIEF.md
# Stacked-Tier Output-Stationary Matrix Multiplier

This block multiplies an ROWS×K matrix A by a K×COLS matrix B using a stack of TIERS identical output-stationary systolic grids, each ROWS×COLS multiply-accumulate cells. The inner dimension K equals TIERS×KSLICE. Tier t handles the slice of K from t×KSLICE up to (t+1)×KSLICE−1. Every tier has its own left-edge port for A and its own top-edge port for B. The block skews the operands internally, so the caller presents one unskewed column of A and one unskewed row of B per tier on each cycle.

A run has three phases. In the first, each cell sums its partial dot product in place. In the second, the cells at each (row, column) position pass a running sum down the stack, one tier per clock cycle. In the third, the bottom tier presents the result one row per cycle on a valid-qualified bus. When the last row has been presented, done goes high and stays high until the next start.

Top module: `tiered_systolic_top`

## Requirements
- R1: After reset, outVld and done are both 0 and stay 0 until a run is started.
- R2: A start pulse sampled while idle or done begins a run. On the k-th clock edge after the start edge (k = 0..KSLICE−1), the block samples column t×KSLICE+k of A (row i in aIn bits [(t×ROWS+i)×8 +: 8]) and row t×KSLICE+k of B (column j in bIn bits [(t×COLS+j)×8 +: 8]) for every tier t. Result element (i,j) equals the sum over all K of A[i][k]·B[k][j].
- R3: Operands are signed two's-complement 8-bit values. Each result is the exact sum truncated modulo 2^16, with no saturation.
- R4: outVld first goes high right after the (KSLICE+ROWS+COLS+TIERS−3)-th clock edge that follows the start edge.
- R5: outVld stays high for exactly ROWS consecutive cycles. The result rows appear in order 0 to ROWS−1, one per cycle, with column j in outRow bits [j×16 +: 16].
- R6: done rises on the cycle after the last result row. It stays high until the next start is sampled, and it is never high while outVld is high.
- R7: A start pulse that arrives during a run is ignored. The run's timing and results do not change.
- R8: Each new run clears all accumulators, so its results do not depend on any earlier run.
- R9: Values on aIn and bIn outside the KSLICE sampling cycles of a run have no effect on the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a run when idle or done |
| aIn | input | TIERS×ROWS×8 | Per-tier column slice of A, one 8-bit value per row |
| bIn | input | TIERS×COLS×8 | Per-tier row slice of B, one 8-bit value per column |
| outVld | output | 1 | Qualifies outRow during the drain phase |
| outRow | output | COLS×16 | One row of the result matrix |
| done | output | 1 | High after the last row, until the next start |

## Verification
The multiplier is driven with several matrix pairs:
- Small positive values expose ordering and skew errors.
- Mixed signs separate signed from unsigned products.
- Extreme values of ±127 and −128 force the 16-bit sum to wrap.
- A pair with only the lower tier's slice non-zero, and another with only the upper slice non-zero, shows whether the cross-tier chain carries each tier's partial sum to the bottom.

Two runs place junk on the operand ports outside the sampling window. One run pulses start mid-run. Every run begins on top of a previous non-zero result. These runs separate correct gating and clearing from leakage.

// File: rtl/tsa_pkg.sv
package tsa_pkg;
  localparam int OPW = 8;
  localparam int ACCW = 16;

  typedef struct packed {
    logic       clr;      // clear every accumulator and skew stage
    logic       feed;     // pass port operands into the skew lines
    logic       acc;      // in-place multiply-accumulate phase
    logic       red;      // cross-tier reduction step
    logic [7:0] redTier;  // tier that adds the sum from above
    logic       drain;    // bottom tier presents a row
    logic [7:0] drainRow; // row being presented
  } ctrlStrobe_t;
endpackage

// File: rtl/tsa_mac.sv
module tsa_mac
  import tsa_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            clr,
  input  logic            accEn,
  input  logic            redEn,
  input  logic [OPW-1:0]  aLeft,
  input  logic [OPW-1:0]  bTop,
  input  logic [ACCW-1:0] sumAbove,
  output logic [OPW-1:0]  aOut,
  output logic [OPW-1:0]  bOut,
  output logic [ACCW-1:0] acc
);
  logic signed [ACCW-1:0] prod;
  assign prod = ACCW'($signed(aLeft) * $signed(bTop));

  always_ff @(posedge clk) begin
    if (!rstN || clr) begin
      aOut <= '0;
      bOut <= '0;
      acc  <= '0;
    end else begin
      aOut <= aLeft;
      bOut <= bTop;
      if (redEn)      acc <= acc + sumAbove;
      else if (accEn) acc <= acc + prod;
    end
  end

  // R8: without a strobe the accumulator holds its value
  p_acc_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!clr && !accEn && !redEn) |=> $stable(acc));
endmodule

// File: rtl/tsa_ctrl.sv
module tsa_ctrl
  import tsa_pkg::*;
#(
  parameter int TIERS  = 2,
  parameter int ROWS   = 2,
  parameter int COLS   = 2,
  parameter int KSLICE = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  output ctrlStrobe_t st,
  output logic        done
);
  localparam int ACC_CYC = KSLICE + ROWS + COLS - 2;

  typedef enum logic [2:0] {S_IDLE, S_ACC, S_RED, S_DRAIN, S_DONE} state_t;
  state_t state;
  logic [15:0] cnt;
  logic        idle;

  assign idle = (state == S_IDLE) || (state == S_DONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        S_IDLE, S_DONE: if (start) begin
          state <= S_ACC;
          cnt   <= '0;
        end
        S_ACC: if (int'(cnt) == ACC_CYC - 1) begin
          cnt   <= '0;
          state <= (TIERS > 1) ? S_RED : S_DRAIN;
        end else cnt <= cnt + 16'd1;
        S_RED: if (int'(cnt) == TIERS - 2) begin
          cnt   <= '0;
          state <= S_DRAIN;
        end else cnt <= cnt + 16'd1;
        S_DRAIN: if (int'(cnt) == ROWS - 1) begin
          cnt   <= '0;
          state <= S_DONE;
        end else cnt <= cnt + 16'd1;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    st          = '0;
    st.clr      = idle && start;
    st.acc      = (state == S_ACC);
    st.feed     = (state == S_ACC) && (int'(cnt) < KSLICE);
    st.red      = (state == S_RED);
    st.redTier  = cnt[7:0] + 8'd1;
    st.drain    = (state == S_DRAIN);
    st.drainRow = cnt[7:0];
  end

  assign done = (state == S_DONE);

  // R6: done and valid output are never high together
  p_done_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(done && st.drain));
  // R6: done only rises right after a presented row
  p_done_after_row_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(st.drain));
  // R7: start during accumulation keeps the count advancing
  p_busy_start_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_ACC && int'(cnt) < ACC_CYC - 1 && start)
      |=> (state == S_ACC && cnt == $past(cnt) + 16'd1));
  // R4: drain is entered only from reduction or accumulation
  p_drain_entry_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(st.drain) |-> $past(state == S_RED || state == S_ACC));
endmodule

// File: rtl/tsa_datapath.sv
module tsa_datapath
  import tsa_pkg::*;
#(
  parameter int TIERS  = 2,
  parameter int ROWS   = 2,
  parameter int COLS   = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ctrlStrobe_t                 st,
  input  logic [TIERS*ROWS*OPW-1:0]   aIn,
  input  logic [TIERS*COLS*OPW-1:0]   bIn,
  output logic [COLS*ACCW-1:0]        outRow
);
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1;

  logic [OPW-1:0]  aEdge  [TIERS][ROWS];
  logic [OPW-1:0]  bEdge  [TIERS][COLS];
  logic [OPW-1:0]  aReg   [TIERS][ROWS][COLS];
  logic [OPW-1:0]  bReg   [TIERS][ROWS][COLS];
  logic [ACCW-1:0] accArr [TIERS][ROWS][COLS];

  for (genvar t = 0; t < TIERS; t++) begin : gTier
    // Left-edge skew: row i delayed by i cycles
    for (genvar i = 0; i < ROWS; i++) begin : gASkew
      logic [OPW-1:0] aSrc;
      assign aSrc = st.feed ? aIn[(t*ROWS+i)*OPW +: OPW] : '0;
      if (i == 0) begin : gNoDly
        assign aEdge[t][i] = aSrc;
      end else begin : gDly
        logic [OPW-1:0] pipe [i];
        always_ff @(posedge clk) begin
          if (!rstN || st.clr) begin
            for (int d = 0; d < i; d++) pipe[d] <= '0;
          end else begin
            pipe[0] <= aSrc;
            for (int d = 1; d < i; d++) pipe[d] <= pipe[d-1];
          end
        end
        assign aEdge[t][i] = pipe[i-1];
      end
    end
    // Top-edge skew: column j delayed by j cycles
    for (genvar j = 0; j < COLS; j++) begin : gBSkew
      logic [OPW-1:0] bSrc;
      assign bSrc = st.feed ? bIn[(t*COLS+j)*OPW +: OPW] : '0;
      if (j == 0) begin : gNoDly
        assign bEdge[t][j] = bSrc;
      end else begin : gDly
        logic [OPW-1:0] pipe [j];
        always_ff @(posedge clk) begin
          if (!rstN || st.clr) begin
            for (int d = 0; d < j; d++) pipe[d] <= '0;
          end else begin
            pipe[0] <= bSrc;
            for (int d = 1; d < j; d++) pipe[d] <= pipe[d-1];
          end
        end
        assign bEdge[t][j] = pipe[j-1];
      end
    end

    logic redHere;
    assign redHere = st.red && (int'(st.redTier) == t);

    for (genvar i = 0; i < ROWS; i++) begin : gRow
      for (genvar j = 0; j < COLS; j++) begin : gCol
        logic [OPW-1:0]  aL;
        logic [OPW-1:0]  bT;
        logic [ACCW-1:0] sumUp;
        assign aL = (j == 0) ? aEdge[t][i] : aReg[t][i][(j == 0) ? 0 : j-1];
        assign bT = (i == 0) ? bEdge[t][j] : bReg[t][(i == 0) ? 0 : i-1][j];
        assign sumUp = (t == 0) ? '0 : accArr[(t == 0) ? 0 : t-1][i][j];
        tsa_mac u_mac (
          .clk(clk), .rstN(rstN), .clr(st.clr), .accEn(st.acc),
          .redEn(redHere), .aLeft(aL), .bTop(bT), .sumAbove(sumUp),
          .aOut(aReg[t][i][j]), .bOut(bReg[t][i][j]), .acc(accArr[t][i][j])
        );
      end
    end
  end

  for (genvar j = 0; j < COLS; j++) begin : gOut
    assign outRow[j*ACCW +: ACCW] =
      st.drain ? accArr[TIERS-1][st.drainRow[RW-1:0]][j] : '0;
    // R5: the bottom tier is frozen while rows are being presented
    p_drain_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
      st.drain |=> $stable(accArr[TIERS-1][0][j]));
  end

  // R2: reduction targets only tiers below the top
  p_red_tier_r2: assert property (@(posedge clk) disable iff (!rstN)
    st.red |-> (int'(st.redTier) >= 1 && int'(st.redTier) < TIERS));
endmodule

// File: rtl/tiered_systolic_top.sv
module tiered_systolic_top
  import tsa_pkg::*;
#(
  parameter int TIERS  = 2,
  parameter int ROWS   = 2,
  parameter int COLS   = 2,
  parameter int KSLICE = 3
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        start,
  input  logic [TIERS*ROWS*OPW-1:0]   aIn,
  input  logic [TIERS*COLS*OPW-1:0]   bIn,
  output logic                        outVld,
  output logic [COLS*ACCW-1:0]        outRow,
  output logic                        done
);
  ctrlStrobe_t st;

  tsa_ctrl #(.TIERS(TIERS), .ROWS(ROWS), .COLS(COLS), .KSLICE(KSLICE)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .st(st), .done(done)
  );

  tsa_datapath #(.TIERS(TIERS), .ROWS(ROWS), .COLS(COLS)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .aIn(aIn), .bIn(bIn), .outRow(outRow)
  );

  assign outVld = st.drain;

  // R1: nothing is presented in the cycle after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(!rstN) |-> (!outVld && !done));
endmodule

// File: tb/tiered_systolic_top_tb_top.sv
module tiered_systolic_top_tb_top;
  localparam int TIERS = 2, ROWS = 2, COLS = 2, KSLICE = 3;
  localparam int KTOT = TIERS * KSLICE;
  localparam int LAT = KSLICE + ROWS + COLS + TIERS - 3;

  logic clk = 0, rstN = 0, start = 0;
  logic [TIERS*ROWS*8-1:0] aIn = '0;
  logic [TIERS*COLS*8-1:0] bIn = '0;
  logic outVld, done;
  logic [COLS*16-1:0] outRow;

  int nRun = 0, nFail = 0;
  int matA [ROWS][KTOT];
  int matB [KTOT][COLS];

  always #5 clk = ~clk;

  tiered_systolic_top #(.TIERS(TIERS), .ROWS(ROWS), .COLS(COLS), .KSLICE(KSLICE)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .aIn(aIn), .bIn(bIn),
    .outVld(outVld), .outRow(outRow), .done(done)
  );

  task automatic check(input string req, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic runMat(input string tag, input bit junk, input bit busyStart);
    int cyc;
    @(negedge clk);
    start = 1;
    @(posedge clk);
    @(negedge clk);
    start = 0;
    for (int k = 0; k < KSLICE; k++) begin
      for (int t = 0; t < TIERS; t++) begin
        for (int i = 0; i < ROWS; i++) aIn[(t*ROWS+i)*8 +: 8] = 8'(matA[i][t*KSLICE+k]);
        for (int j = 0; j < COLS; j++) bIn[(t*COLS+j)*8 +: 8] = 8'(matB[t*KSLICE+k][j]);
      end
      @(posedge clk);
      @(negedge clk);
    end
    aIn = junk ? {TIERS*ROWS{8'h7b}} : '0;
    bIn = junk ? {TIERS*COLS{8'hc5}} : '0;
    cyc = KSLICE;
    while (!outVld && cyc < 100) begin
      if (busyStart && cyc == KSLICE) start = 1;
      @(posedge clk);
      @(negedge clk);
      start = 0;
      cyc++;
    end
    check({tag, " R4 latency"}, cyc, LAT);
    for (int r = 0; r < ROWS; r++) begin
      check({tag, " R5 valid"}, int'(outVld), 1);
      for (int j = 0; j < COLS; j++) begin
        int sum = 0;
        for (int k = 0; k < KTOT; k++) sum += matA[r][k] * matB[k][j];
        check({tag, " R2 R3 element"}, int'(outRow[j*16 +: 16]), sum & 16'hffff);
      end
      @(posedge clk);
      @(negedge clk);
    end
    check({tag, " R5 valid low"}, int'(outVld), 0);
    check({tag, " R6 done"}, int'(done), 1);
    aIn = '0;
    bIn = '0;
  endtask

  task automatic fillPlain(input int sa, input int sb);
    for (int i = 0; i < ROWS; i++)
      for (int k = 0; k < KTOT; k++) matA[i][k] = sa * (i + k + 1);
    for (int k = 0; k < KTOT; k++)
      for (int j = 0; j < COLS; j++) matB[k][j] = sb * (2*k - j + 1);
  endtask

  task automatic testReset();
    check("R1 outVld after reset", int'(outVld), 0);
    check("R1 done after reset", int'(done), 0);
  endtask

  task automatic testBasic();
    fillPlain(1, 1);
    runMat("basic", 0, 0);
  endtask

  task automatic testSigned();
    for (int i = 0; i < ROWS; i++)
      for (int k = 0; k < KTOT; k++) matA[i][k] = ((i + k) % 2 == 0) ? -(k + 3) : (i + 5);
    for (int k = 0; k < KTOT; k++)
      for (int j = 0; j < COLS; j++) matB[k][j] = (j == 0) ? -(k + 1) : (7 - 3*k);
    runMat("signed R3", 0, 0);
  endtask

  task automatic testWrap();
    for (int i = 0; i < ROWS; i++)
      for (int k = 0; k < KTOT; k++) matA[i][k] = (i == 0) ? 127 : -128;
    for (int k = 0; k < KTOT; k++)
      for (int j = 0; j < COLS; j++) matB[k][j] = (j == 0) ? 127 : -128;
    runMat("wrap R3", 0, 0);
  endtask

  task automatic testTierIso(input int live);
    fillPlain(1, 1);
    for (int i = 0; i < ROWS; i++)
      for (int k = 0; k < KTOT; k++)
        if (k / KSLICE != live) matA[i][k] = 0;
    runMat(live == 0 ? "upper tier only R2" : "lower tier only R2", 0, 0);
  endtask

  task automatic testJunk();
    fillPlain(2, -1);
    runMat("junk outside window R9", 1, 0);
  endtask

  task automatic testBusyStart();
    fillPlain(-1, 3);
    runMat("start while busy R7", 0, 1);
  endtask

  task automatic testDoneHold();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R6 done held", int'(done), 1);
    check("R6 no valid while done", int'(outVld), 0);
  endtask

  task automatic testReuse();
    fillPlain(1, 0);
    runMat("clear between runs R8", 1, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    testReset();
    rstN = 1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    testReset();
    testBasic();
    testDoneHold();
    testSigned();
    testWrap();
    testTierIso(0);
    testTierIso(1);
    testJunk();
    testBusyStart();
    testReuse();
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nRun++;
    nFail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule